// File: doc/BRIEF.md
# Double-Buffered SPI Transmit Engine

This block is a transmit-only SPI master for long byte streams, such as LED strip refresh data, where the serial clock must not pause between bursts. A 64-byte register file, organised as sixteen 32-bit words, is split into two banks of eight words. The shifter drains one bank while the host writes the other. The two banks swap roles each time the active bank runs out. If the host has committed the idle bank by then, SCLK keeps running through the swap with no extra cycles.

The host writes words into a bank whose empty flag is high. It then commits the bank with a byte count and a final-bank marker. The engine reports each drained bank with an empty flag and a one-cycle interrupt pulse. It reports the end of a transfer with a done pulse, which is issued in the cycle the chip select is released. If the next bank is not committed in time, the engine parks SCLK low with chip select held, and raises a sticky underrun flag. It resumes on the next commit, or it closes the transfer when the host asks it to end.

Top module: `pingpong_spi_tx`

## Requirements
- R1: The buffer holds 2 banks of 8 words of 32 bits each. `wr_addr[3]` selects the bank and `wr_addr[2:0]` selects the word. A write to a bank whose `bank_empty` bit is low is ignored.
- R2: A pulse on `commit[b]` while `bank_empty[b]` is high marks bank b full. It latches `commit_len` (a byte count from 1 to 32) and `commit_last`. A commit to a bank that is already full changes nothing.
- R3: Bytes leave in word order 0 upward. Within a word, the least significant byte goes first. Within a byte, the MSB goes first. The interface uses SPI mode 0: SCLK idles low, and MOSI changes only on falling SCLK edges, so it is stable while SCLK is high.
- R4: The SCLK half period is `clk_div`+1 system cycles. Consecutive rising SCLK edges are exactly 2(`clk_div`+1) cycles apart throughout a transfer, including across bank swaps, whenever the next bank is committed in time.
- R5: A transfer starts from bank 0 once bank 0 is full while the engine is idle. The banks then alternate 0, 1, 0, ...
- R6: `cs_n` falls 2(`clk_div`+1) cycles before the first rising SCLK edge. After the last falling edge of the final bank, `cs_n` returns high 2(`clk_div`+1) cycles later. `xfer_done` pulses for one cycle in that same cycle.
- R7: When the last bit of a bank has been shifted out, `bank_empty[b]` goes high and `bank_irq[b]` pulses for one cycle, once per drained bank.
- R8: If the next bank is not full when the current bank ends, SCLK stays low and `cs_n` stays low, and `underrun` is set. Shifting resumes once that bank is committed. `underrun` stays set until the next transfer begins.
- R9: An `end_xfer` pulse during an underrun stall closes the transfer: `cs_n` rises 2(`clk_div`+1) cycles later, with `xfer_done`. At any other time `end_xfer` is ignored. The next transfer starts from bank 0.
- R10: A bank committed with count L sends exactly L bytes, taken from the start of the bank.
- R11: After reset, `cs_n` is 1, `sclk`, `mosi`, `underrun`, `xfer_done` and `bank_irq` are 0, and `bank_empty` is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | 8 | SCLK half period minus one, in system cycles |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | 4 | Bank (bit 3) and word index (bits 2:0) |
| wr_data | input | 32 | Word to store |
| commit | input | 2 | Per-bank commit pulse |
| commit_len | input | 6 | Byte count for the committed bank, 1 to 32 |
| commit_last | input | 1 | Committed bank is the final one of the transfer |
| end_xfer | input | 1 | Close the transfer while stalled |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | SPI data out |
| cs_n | output | 1 | Active-low chip select |
| bank_empty | output | 2 | Bank may be written by the host |
| bank_irq | output | 2 | One-cycle pulse when a bank has drained |
| xfer_done | output | 1 | One-cycle pulse when the transfer closes |
| underrun | output | 1 | Sticky: a bank swap found the next bank empty |

## Verification
A wrong bank pointer or byte index shows at once as bytes out of order in the captured MOSI stream. A lost full flag shows as a stretched SCLK interval at the very next bank swap. The bench therefore times every rising edge against the exact period and compares every received byte with an arithmetic pattern. A corrupted trailer or a missing stall state shows within two half periods, either in the chip select timing or as SCLK edges appearing while the engine should be parked.

// File: rtl/pp_spi_pkg.sv
package pp_spi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_STALL,
    ST_TRAIL
  } tx_state_e;
endpackage

// File: rtl/pp_spi_regfile.sv
module pp_spi_regfile #(
  parameter int WORD_W     = 32,
  parameter int BANK_WORDS = 8,
  localparam int WA_W      = $clog2(BANK_WORDS),
  localparam int ADDR_W    = WA_W + 1,
  localparam int DEPTH     = 2 * BANK_WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        bank_full,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en && !bank_full[wr_addr[ADDR_W-1]])
      mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

  // R1: a bank owned by the shifter is protected from host writes
  p_locked_bank_r1: assert property (@(posedge clk) disable iff (rst)
    wr_en && bank_full[wr_addr[ADDR_W-1]] |=> mem[$past(wr_addr)] == $past(mem[wr_addr]));
endmodule

// File: rtl/pp_spi_clkgen.sv
module pp_spi_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] clk_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == clk_div);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (!run || tick)
      cnt <= '0;
    else
      cnt <= cnt + DIV_W'(1);
  end

  // R4: every running phase starts a fresh half period
  p_fresh_half_r4: assert property (@(posedge clk) disable iff (rst)
    run && !$past(run) |-> cnt == '0);
endmodule

// File: rtl/pp_spi_bankctl.sv
module pp_spi_bankctl #(
  parameter int BANK_BYTES = 32,
  localparam int BI_W      = $clog2(BANK_BYTES),
  localparam int LEN_W     = BI_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            commit,
  input  logic [LEN_W-1:0]      commit_len,
  input  logic                  commit_last,
  input  logic                  drain,
  input  logic                  drain_bank,
  output logic [1:0]            full,
  output logic [1:0][BI_W-1:0]  lenm1,
  output logic [1:0]            last,
  output logic [1:0]            bank_empty,
  output logic [1:0]            bank_irq
);
  logic [LEN_W-1:0] len_dec;
  assign len_dec    = commit_len - LEN_W'(1);
  assign bank_empty = ~full;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic hit;
    assign hit = drain && (drain_bank == 1'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        full[b]     <= 1'b0;
        lenm1[b]    <= '0;
        last[b]     <= 1'b0;
        bank_irq[b] <= 1'b0;
      end else begin
        bank_irq[b] <= hit;
        if (hit)
          full[b] <= 1'b0;
        else if (commit[b] && !full[b]) begin
          full[b]  <= 1'b1;
          lenm1[b] <= len_dec[BI_W-1:0];
          last[b]  <= commit_last;
        end
      end
    end

    // R2: a second commit cannot alter a bank already handed over
    p_commit_ignored_r2: assert property (@(posedge clk) disable iff (rst)
      full[b] && commit[b] && !hit |=> full[b] && $stable(lenm1[b]) && $stable(last[b]));
    // R7: the interrupt coincides with the bank becoming free
    p_irq_frees_r7: assert property (@(posedge clk) disable iff (rst)
      bank_irq[b] |-> !full[b]);
  end

  // R7: only one bank drains at a time
  p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_irq));
endmodule

// File: rtl/pp_spi_shifter.sv
module pp_spi_shifter
  import pp_spi_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int BANK_WORDS = 8,
  localparam int WA_W      = $clog2(BANK_WORDS),
  localparam int ADDR_W    = WA_W + 1,
  localparam int BPW       = WORD_W / 8,
  localparam int BW_W      = $clog2(BPW),
  localparam int BANK_BYTES = BANK_WORDS * BPW,
  localparam int BI_W      = $clog2(BANK_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic [1:0]           full,
  input  logic [1:0][BI_W-1:0] lenm1,
  input  logic [1:0]           last,
  input  logic                 end_xfer,
  input  logic [WORD_W-1:0]    rd_data,
  output logic [ADDR_W-1:0]    rd_addr,
  output logic                 run,
  output logic                 drain,
  output logic                 drain_bank,
  output logic                 sclk,
  output logic                 mosi,
  output logic                 cs_n,
  output logic                 xfer_done,
  output logic                 underrun
);
  tx_state_e       st;
  logic            cur;
  logic [BI_W-1:0] bidx;
  logic [2:0]      bitc;
  logic [7:0]      sr;
  logic            ph;

  logic            more_in_bank;
  logic            ld_bank;
  logic [BI_W-1:0] ld_bidx;
  logic [7:0]      ld_byte;

  assign more_in_bank = (bidx != lenm1[cur]);

  always_comb begin
    case (st)
      ST_IDLE:  begin ld_bank = 1'b0; ld_bidx = '0; end
      ST_STALL: begin ld_bank = cur;  ld_bidx = '0; end
      default: begin
        if (more_in_bank) begin
          ld_bank = cur;
          ld_bidx = bidx + BI_W'(1);
        end else begin
          ld_bank = ~cur;
          ld_bidx = '0;
        end
      end
    endcase
  end

  assign rd_addr = {ld_bank, ld_bidx[BI_W-1:BW_W]};
  assign ld_byte = rd_data[{ld_bidx[BW_W-1:0], 3'b000} +: 8];
  assign run     = (st == ST_LEAD) || (st == ST_SHIFT) || (st == ST_TRAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cur        <= 1'b0;
      bidx       <= '0;
      bitc       <= '0;
      sr         <= '0;
      ph         <= 1'b0;
      sclk       <= 1'b0;
      mosi       <= 1'b0;
      cs_n       <= 1'b1;
      xfer_done  <= 1'b0;
      underrun   <= 1'b0;
      drain      <= 1'b0;
      drain_bank <= 1'b0;
    end else begin
      xfer_done <= 1'b0;
      drain     <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (full[0]) begin
            st       <= ST_LEAD;
            cs_n     <= 1'b0;
            cur      <= 1'b0;
            bidx     <= '0;
            bitc     <= 3'd7;
            sr       <= ld_byte;
            mosi     <= ld_byte[7];
            underrun <= 1'b0;
          end
        end
        ST_LEAD: begin
          if (tick) st <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (bitc != 3'd0) begin
                bitc <= bitc - 3'd1;
                mosi <= sr[6];
                sr   <= {sr[6:0], 1'b0};
              end else if (more_in_bank) begin
                bidx <= bidx + BI_W'(1);
                bitc <= 3'd7;
                sr   <= ld_byte;
                mosi <= ld_byte[7];
              end else begin
                drain      <= 1'b1;
                drain_bank <= cur;
                if (last[cur]) begin
                  st   <= ST_TRAIL;
                  ph   <= 1'b0;
                  mosi <= 1'b0;
                end else begin
                  cur  <= ~cur;
                  bidx <= '0;
                  bitc <= 3'd7;
                  if (full[~cur]) begin
                    sr   <= ld_byte;
                    mosi <= ld_byte[7];
                  end else begin
                    st       <= ST_STALL;
                    underrun <= 1'b1;
                    mosi     <= 1'b0;
                  end
                end
              end
            end
          end
        end
        ST_STALL: begin
          if (end_xfer) begin
            st <= ST_TRAIL;
            ph <= 1'b0;
          end else if (full[cur]) begin
            st   <= ST_SHIFT;
            sr   <= ld_byte;
            mosi <= ld_byte[7];
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            if (!ph) begin
              ph <= 1'b1;
            end else begin
              cs_n      <= 1'b1;
              xfer_done <= 1'b1;
              cur       <= 1'b0;
              st        <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: SCLK toggles only while shifting
  p_sclk_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    st != ST_SHIFT |-> !sclk);
  // R3: data is held while the slave samples
  p_mosi_hold_r3: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));
  // R6: completion is flagged exactly when chip select releases
  p_done_release_r6: assert property (@(posedge clk) disable iff (rst)
    xfer_done |-> cs_n && !$past(cs_n));
  // R8: a stall parks the bus with select held and the flag raised
  p_stall_parked_r8: assert property (@(posedge clk) disable iff (rst)
    st == ST_STALL |-> underrun && !cs_n && !sclk);
  // R11: idle means deselected and quiet
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    st == ST_IDLE |-> cs_n && !sclk);
endmodule

// File: rtl/pingpong_spi_tx.sv
module pingpong_spi_tx #(
  parameter int WORD_W     = 32,
  parameter int BANK_WORDS = 8,
  parameter int DIV_W      = 8,
  localparam int WA_W      = $clog2(BANK_WORDS),
  localparam int ADDR_W    = WA_W + 1,
  localparam int BANK_BYTES = BANK_WORDS * (WORD_W / 8),
  localparam int BI_W      = $clog2(BANK_BYTES),
  localparam int LEN_W     = BI_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        commit,
  input  logic [LEN_W-1:0]  commit_len,
  input  logic              commit_last,
  input  logic              end_xfer,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic [1:0]        bank_empty,
  output logic [1:0]        bank_irq,
  output logic              xfer_done,
  output logic              underrun
);
  logic [1:0]            full;
  logic [1:0][BI_W-1:0]  lenm1;
  logic [1:0]            last;
  logic                  drain;
  logic                  drain_bank;
  logic                  run;
  logic                  tick;
  logic [ADDR_W-1:0]     rd_addr;
  logic [WORD_W-1:0]     rd_data;

  pp_spi_regfile #(.WORD_W(WORD_W), .BANK_WORDS(BANK_WORDS)) u_regfile (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .bank_full(full), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  pp_spi_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst(rst), .run(run), .clk_div(clk_div), .tick(tick)
  );

  pp_spi_bankctl #(.BANK_BYTES(BANK_BYTES)) u_bankctl (
    .clk(clk), .rst(rst), .commit(commit), .commit_len(commit_len),
    .commit_last(commit_last), .drain(drain), .drain_bank(drain_bank),
    .full(full), .lenm1(lenm1), .last(last), .bank_empty(bank_empty),
    .bank_irq(bank_irq)
  );

  pp_spi_shifter #(.WORD_W(WORD_W), .BANK_WORDS(BANK_WORDS)) u_shifter (
    .clk(clk), .rst(rst), .tick(tick), .full(full), .lenm1(lenm1), .last(last),
    .end_xfer(end_xfer), .rd_data(rd_data), .rd_addr(rd_addr), .run(run),
    .drain(drain), .drain_bank(drain_bank), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .xfer_done(xfer_done), .underrun(underrun)
  );
endmodule

// File: tb/pingpong_spi_tx_tb.sv
`timescale 1ns/1ps
module pingpong_spi_tx_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  clk_div = 8'd0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  commit = '0;
  logic [5:0]  commit_len = '0;
  logic        commit_last = 1'b0;
  logic        end_xfer = 1'b0;
  logic        sclk, mosi, cs_n, xfer_done, underrun;
  logic [1:0]  bank_empty, bank_irq;

  always #2.5 clk = ~clk;

  pingpong_spi_tx u_dut (
    .clk(clk), .rst(rst), .clk_div(clk_div), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit), .commit_len(commit_len),
    .commit_last(commit_last), .end_xfer(end_xfer), .sclk(sclk), .mosi(mosi),
    .cs_n(cs_n), .bank_empty(bank_empty), .bank_irq(bank_irq),
    .xfer_done(xfer_done), .underrun(underrun)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int t, input int k);
    return 8'((k * 7 + t * 13 + 1) & 255);
  endfunction

  // port monitor, sampled on falling clock edges
  logic [7:0] rx [0:255];
  int rx_cnt, bitn, cyc, cs_fall_cyc, last_rise, last_fall;
  int lead_meas, trail_meas, gap_bad, done_cnt, done_bad, rise_cnt;
  int irq_cnt [2];
  int exp_period;
  bit first_rise, gap_chk;
  logic [7:0] shb;
  logic sclk_p = 1'b0, cs_p = 1'b1;

  task automatic clear_mon();
    rx_cnt = 0; bitn = 0; gap_bad = 0; done_bad = 0;
    lead_meas = -1; trail_meas = -1; irq_cnt[0] = 0; irq_cnt[1] = 0;
  endtask

  initial begin
    cyc = 0; done_cnt = 0; rise_cnt = 0; gap_chk = 1; exp_period = 2;
    first_rise = 0; shb = '0; last_rise = 0; last_fall = 0; cs_fall_cyc = 0;
    clear_mon();
  end

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if (!cs_n && cs_p) begin
        cs_fall_cyc = cyc;
        first_rise = 1;
      end
      if (sclk && !sclk_p) begin
        rise_cnt++;
        shb = {shb[6:0], mosi};
        bitn++;
        if (bitn == 8) begin
          rx[rx_cnt[7:0]] = shb;
          rx_cnt++;
          bitn = 0;
        end
        if (first_rise) begin
          lead_meas = cyc - cs_fall_cyc;
          first_rise = 0;
        end else if (gap_chk && (cyc - last_rise != exp_period)) begin
          gap_bad++;
        end
        last_rise = cyc;
      end
      if (!sclk && sclk_p) last_fall = cyc;
      if (cs_n && !cs_p) begin
        trail_meas = cyc - last_fall;
        if (!xfer_done) done_bad++;
      end
      if (xfer_done) done_cnt++;
      if (bank_irq[0]) irq_cnt[0]++;
      if (bank_irq[1]) irq_cnt[1]++;
      sclk_p = sclk;
      cs_p = cs_n;
    end
  end

  task automatic wr_word(input int b, input int w, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 4'((b << 3) | w); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fill(input int b, input int base, input int t);
    for (int w = 0; w < 8; w++)
      wr_word(b, w, {pat(t, base + 4*w + 3), pat(t, base + 4*w + 2),
                     pat(t, base + 4*w + 1), pat(t, base + 4*w)});
  endtask

  task automatic do_commit(input int b, input int len, input bit lst);
    commit = 2'(1 << b); commit_len = 6'(len); commit_last = lst;
    @(negedge clk);
    commit = '0; commit_last = 1'b0;
  endtask

  task automatic wait_done(input int d0);
    while (done_cnt == d0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic int data_bad(input int t, input int n);
    int bad = 0;
    for (int k = 0; k < n; k++) if (rx[k] !== pat(t, k)) bad++;
    return bad;
  endfunction

  task automatic stream(input int div, input int nb, input int lastlen, input int t);
    int d0, hp, nbytes;
    clk_div = 8'(div); hp = 2 * (div + 1); exp_period = hp;
    clear_mon(); d0 = done_cnt;
    for (int c = 0; c < nb; c++) begin
      while (!bank_empty[c % 2]) @(negedge clk);
      fill(c % 2, c * 32, t);
      do_commit(c % 2, (c == nb - 1) ? lastlen : 32, c == nb - 1);
    end
    wait_done(d0);
    nbytes = 32 * (nb - 1) + lastlen;
    chk(rx_cnt == nbytes, $sformatf("R10 stream byte count div=%0d", div), rx_cnt, nbytes);
    chk(data_bad(t, nbytes) == 0, $sformatf("R3 R5 byte order div=%0d", div), data_bad(t, nbytes), 0);
    chk(gap_bad == 0, $sformatf("R4 continuous SCLK div=%0d", div), gap_bad, 0);
    chk(lead_meas == hp, $sformatf("R6 select lead div=%0d", div), lead_meas, hp);
    chk(trail_meas == hp, $sformatf("R6 select trail div=%0d", div), trail_meas, hp);
    chk(done_bad == 0 && done_cnt == d0 + 1, "R6 done pulse at release", done_cnt - d0, 1);
    chk(underrun == 1'b0, "R8 no underrun when fed in time", int'(underrun), 0);
    chk(irq_cnt[0] == (nb + 1) / 2, "R7 bank 0 interrupts", irq_cnt[0], (nb + 1) / 2);
    chk(irq_cnt[1] == nb / 2, "R7 bank 1 interrupts", irq_cnt[1], nb / 2);
    chk(bank_empty == 2'b11, "R7 banks empty after transfer", int'(bank_empty), 3);
  endtask

  initial begin
    int d0, r0, n;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(cs_n == 1'b1, "R11 cs_n after reset", int'(cs_n), 1);
    chk(sclk == 1'b0 && mosi == 1'b0, "R11 sclk/mosi after reset", int'({sclk, mosi}), 0);
    chk(bank_empty == 2'b11, "R11 bank_empty after reset", int'(bank_empty), 3);
    chk(underrun == 1'b0 && xfer_done == 1'b0 && bank_irq == 2'b00,
        "R11 flags after reset", int'({underrun, xfer_done, bank_irq}), 0);

    // R4 R5 R6 R7: streaming at several dividers, full and partial last banks
    stream(0, 5, 32, 1);
    stream(1, 5, 17, 2);
    stream(3, 5, 5, 3);

    // R1 R2 R9: write and commit to a busy bank, end_xfer while shifting
    clk_div = 8'd1; exp_period = 4; clear_mon(); d0 = done_cnt;
    fill(0, 0, 4);
    do_commit(0, 4, 1'b1);
    wr_word(0, 0, 32'hFFFF_FFFF);
    do_commit(0, 32, 1'b0);
    repeat (10) @(negedge clk);
    end_xfer = 1'b1; @(negedge clk); end_xfer = 1'b0;
    wait_done(d0);
    chk(rx_cnt == 4, "R2 R9 commit to full bank and stray end_xfer ignored", rx_cnt, 4);
    chk(data_bad(4, 4) == 0, "R1 write to full bank ignored", data_bad(4, 4), 0);

    // R8: underrun stall, resume, sticky flag
    clear_mon(); d0 = done_cnt; gap_chk = 0;
    fill(0, 0, 5);
    do_commit(0, 4, 1'b0);
    while (!underrun) @(negedge clk);
    r0 = rise_cnt;
    repeat (100) @(negedge clk);
    chk(rise_cnt == r0, "R8 SCLK parked during stall", rise_cnt - r0, 0);
    chk(cs_n == 1'b0 && sclk == 1'b0, "R8 select held low during stall", int'({cs_n, sclk}), 0);
    fill(1, 4, 5);
    do_commit(1, 3, 1'b1);
    wait_done(d0);
    chk(rx_cnt == 7 && data_bad(5, 7) == 0, "R8 resume after late commit", rx_cnt, 7);
    chk(underrun == 1'b1, "R8 underrun sticky after transfer", int'(underrun), 1);
    clear_mon(); d0 = done_cnt;
    fill(0, 0, 6);
    do_commit(0, 1, 1'b1);
    wait_done(d0);
    chk(underrun == 1'b0, "R8 underrun cleared by new transfer", int'(underrun), 0);

    // R9: end_xfer during stall closes, next transfer starts at bank 0
    clear_mon(); d0 = done_cnt;
    fill(0, 0, 7);
    do_commit(0, 2, 1'b0);
    while (!underrun) @(negedge clk);
    end_xfer = 1'b1; @(negedge clk); end_xfer = 1'b0;
    n = 1;
    while (!cs_n && n < 50) begin @(negedge clk); n++; end
    chk(n == 5, "R9 select release after end_xfer", n, 5);
    repeat (2) @(negedge clk);
    chk(done_cnt == d0 + 1 && rx_cnt == 2, "R9 done and bytes after end_xfer", rx_cnt, 2);
    clear_mon(); d0 = done_cnt; gap_chk = 1;
    fill(0, 0, 8);
    do_commit(0, 1, 1'b1);
    wait_done(d0);
    chk(rx_cnt == 1 && data_bad(8, 1) == 0, "R5 R9 restart from bank 0", rx_cnt, 1);

    // R10: sweep every byte count on a single bank
    clk_div = 8'd0; exp_period = 2;
    for (int len = 1; len <= 32; len++) begin
      clear_mon(); d0 = done_cnt;
      fill(0, 0, 20 + len);
      do_commit(0, len, 1'b1);
      wait_done(d0);
      chk(rx_cnt == len, $sformatf("R10 byte count len=%0d", len), rx_cnt, len);
      chk(data_bad(20 + len, len) == 0 && gap_bad == 0,
          $sformatf("R10 data len=%0d", len), data_bad(20 + len, len), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule